// File: doc/BRIEF.md
# Dual-Input 5/3 Lifting Row Transform

This block performs the forward one-dimensional integer 5/3 lifting transform along image rows. Each accepted clock delivers a pair of pixels: the even-indexed sample of the pair and the odd-indexed sample that precedes it in the row. Each accepted pair yields one high-pass (detail) and one low-pass (approximation) coefficient. The block therefore keeps full throughput: two pixels in and two coefficients out on every accepted cycle.

The transform is built from two copies of one generic lifting element, a predict step followed by an update step. Each element adds two operands in a first register stage. In a second register stage it adds or subtracts the wired arithmetic shift of that sum to a third operand. Delay lines realign the previous even sample and the high-pass result with the update output. A row-start marker travelling with the pair zeroes the missing left neighbours. Pairs with in_valid low are dropped and leave the transform state untouched.

Top module: `dwt53_row_lift`

## Requirements
- R1: While rst is high and in the first six cycles after it falls, out_valid is 0 and out_low and out_high are 0.
- R2: A pair sampled with in_valid high at a rising edge produces out_valid high exactly six cycles later. A cycle with in_valid low produces out_valid low six cycles later.
- R3: For the k-th accepted pair (even e_k, odd o_k), with pixels read as unsigned and widened to 16-bit signed, out_high = o_k - floor((e_k + e_left) / 2). Here e_left is the even sample of the previous accepted pair.
- R4: out_low = e_left + floor((H_k + H_left) / 4), where H_left is the high-pass result of the previous accepted pair. The division rounds toward minus infinity for negative sums, as an arithmetic right shift does.
- R5: A pair accepted with in_sor high starts a row: e_left and H_left are taken as 0 for it. The first pair after reset is treated the same way.
- R6: Cycles with in_valid low are ignored, including any in_sor value on them. The next accepted pair uses the last accepted pair as its left neighbour.
- R7: While out_valid is 0, out_low and out_high keep their last values.
- R8: Every valid out_high lies in [-(2^8-1), 2^8-1] and every valid out_low lies in [-128, 382], both as 16-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pair on in_even/in_odd is to be accepted |
| in_sor | input | 1 | Accepted pair is the first of a row |
| in_even | input | 8 | Even-indexed pixel, unsigned |
| in_odd | input | 8 | Odd-indexed pixel preceding the even one, unsigned |
| out_valid | output | 1 | Coefficient pair on outputs is new |
| out_low | output | 16 | Low-pass coefficient, signed |
| out_high | output | 16 | High-pass coefficient, signed |

## Verification
The bench drives rows that push the arithmetic to its edges: saturated and empty rows, and alternating extremes whose high-pass sums go negative. A design that shifted negative sums logically would give huge positive low-pass values. One that rounded toward zero would be off by one on odd negative sums. Row markers placed back to back, and markers arriving on idle cycles, expose a design that leaks the previous row's neighbours into a new row, or that honours a marker with no data. Random idle gaps inside rows catch history registers that advance on dropped cycles and a valid strobe that is not carried through every pipeline register.

// File: rtl/dwt53_pkg.sv
package dwt53_pkg;

    localparam int COEF_W = 16;

    typedef logic signed [COEF_W-1:0] coef_t;

    typedef struct packed {
        logic  valid;
        logic  sor;
        coef_t even;
        coef_t odd;
    } pair_t;

    // Arithmetic right shift by a constant amount: pure wiring with the
    // sign bit copied into the vacated upper positions.
    function automatic coef_t wired_asr(coef_t x, int unsigned sh);
        coef_t r;
        for (int i = 0; i < COEF_W; i++) begin
            if (i + sh < COEF_W) r[i] = x[i + sh];
            else                 r[i] = x[COEF_W-1];
        end
        return r;
    endfunction

endpackage

// File: rtl/dwt53_align_delay.sv
module dwt53_align_delay #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/dwt53_lift_pe.sv
module dwt53_lift_pe
    import dwt53_pkg::*;
#(
    parameter int unsigned SHIFT  = 1,
    parameter bit          NEGATE = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  coef_t in_a,
    input  coef_t in_b,
    input  coef_t in_c,
    output logic  out_valid,
    output coef_t out_y
);
    coef_t d_sum;
    coef_t d_pass;
    logic  v_mid;
    coef_t scaled;

    // Stage 1: pair sum and pass-through operand
    always_ff @(posedge clk) begin
        if (rst) begin
            d_sum  <= '0;
            d_pass <= '0;
            v_mid  <= 1'b0;
        end else begin
            d_sum  <= in_a + in_b;
            d_pass <= in_c;
            v_mid  <= in_valid;
        end
    end

    assign scaled = wired_asr(d_sum, SHIFT);

    // Stage 2: combine with wired-scaled sum
    always_ff @(posedge clk) begin
        if (rst) begin
            out_y     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_y     <= NEGATE ? (d_pass - scaled) : (d_pass + scaled);
            out_valid <= v_mid;
        end
    end

    AST_PE_VALID_CARRIED: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid); // R2
    AST_PE_IDLE_CARRIED: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid); // R2
endmodule

// File: rtl/dwt53_row_lift.sv
module dwt53_row_lift
    import dwt53_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sor,
    input  logic [PIX_W-1:0] in_even,
    input  logic [PIX_W-1:0] in_odd,
    output logic             out_valid,
    output logic [15:0]      out_low,
    output logic [15:0]      out_high
);
    localparam int PAD      = COEF_W - PIX_W;
    localparam int PIX_MAX  = (1 << PIX_W) - 1;
    localparam int L_MIN    = -((PIX_MAX + 1) / 2);
    localparam int L_MAX    = PIX_MAX + (2 * PIX_MAX) / 4;
    localparam int PE_LAT   = 2;

    pair_t in_q;
    coef_t even_hist;
    coef_t even_left;
    coef_t even_left_d;
    logic  p_valid;
    coef_t p_high;
    logic  sor_d;
    coef_t high_hist;
    coef_t high_left;
    coef_t high_d;
    logic  u_valid;
    coef_t u_low;
    coef_t low_q;
    coef_t high_q;
    logic  valid_q;

    // Input register: widen unsigned pixels to signed coefficients
    always_ff @(posedge clk) begin
        if (rst) begin
            in_q <= '0;
        end else begin
            in_q.valid <= in_valid;
            in_q.sor   <= in_sor & in_valid;
            in_q.even  <= coef_t'({{PAD{1'b0}}, in_even});
            in_q.odd   <= coef_t'({{PAD{1'b0}}, in_odd});
        end
    end

    // Previous even sample, advanced only by accepted pairs
    always_ff @(posedge clk) begin
        if (rst)             even_hist <= '0;
        else if (in_q.valid) even_hist <= in_q.even;
    end

    assign even_left = in_q.sor ? '0 : even_hist;

    // Predict step: H = odd - (even + even_left)/2
    dwt53_lift_pe #(.SHIFT(1), .NEGATE(1'b1)) u_predict (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_q.valid),
        .in_a      (in_q.even),
        .in_b      (even_left),
        .in_c      (in_q.odd),
        .out_valid (p_valid),
        .out_y     (p_high)
    );

    // Realign left even sample and row marker with the predict result
    dwt53_align_delay #(.W(COEF_W), .DEPTH(PE_LAT)) u_even_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (even_left),
        .dout (even_left_d)
    );

    dwt53_align_delay #(.W(1), .DEPTH(PE_LAT)) u_sor_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (in_q.sor),
        .dout (sor_d)
    );

    // Previous high-pass result, advanced only by accepted pairs
    always_ff @(posedge clk) begin
        if (rst)          high_hist <= '0;
        else if (p_valid) high_hist <= p_high;
    end

    assign high_left = sor_d ? '0 : high_hist;

    // Update step: L = even_left + (H + H_left)/4
    dwt53_lift_pe #(.SHIFT(2), .NEGATE(1'b0)) u_update (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (p_valid),
        .in_a      (p_high),
        .in_b      (high_left),
        .in_c      (even_left_d),
        .out_valid (u_valid),
        .out_y     (u_low)
    );

    dwt53_align_delay #(.W(COEF_W), .DEPTH(PE_LAT)) u_high_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (p_high),
        .dout (high_d)
    );

    // Output register: loads only on a valid pair, holds otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            low_q   <= '0;
            high_q  <= '0;
        end else begin
            valid_q <= u_valid;
            if (u_valid) begin
                low_q  <= u_low;
                high_q <= high_d;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_low   = low_q;
    assign out_high  = high_q;

    AST_NO_OVERFLOW_HIGH: assert property (@(posedge clk) disable iff (rst)
        p_valid |-> ($signed(p_high) >= -PIX_MAX && $signed(p_high) <= PIX_MAX)); // R8
    AST_NO_OVERFLOW_LOW: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($signed(out_low) >= L_MIN && $signed(out_low) <= L_MAX)); // R8
    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_low)); // R7
    AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_high)); // R7
    AST_TOTAL_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##6 out_valid); // R2
endmodule

// File: tb/tb_dwt53_row_lift.sv
module tb_dwt53_row_lift;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 6;
    localparam int ROW_PAIRS  = 16;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sor = 1'b0;
    logic [7:0] in_even = '0;
    logic [7:0] in_odd = '0;
    logic       out_valid;
    logic [15:0] out_low;
    logic [15:0] out_high;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural model state
    int    m_even_prev = 0;
    int    m_high_prev = 0;
    bit    m_gap = 0;
    int    held_low = 0;
    int    held_high = 0;
    bit    qv[$];
    int    ql[$];
    int    qh[$];
    string qt[$];

    dwt53_row_lift dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sor    (in_sor),
        .in_even   (in_even),
        .in_odd    (in_odd),
        .out_valid (out_valid),
        .out_low   (out_low),
        .out_high  (out_high)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog expired act=%0d exp=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Compare outputs against the entry pushed LAT cycles earlier
    task automatic compare_outputs();
        int al, ah;
        al = int'($signed(out_low));
        ah = int'($signed(out_high));
        if (qv.size() >= LAT) begin
            bit    v;
            int    el, eh;
            string t;
            v  = qv.pop_front();
            el = ql.pop_front();
            eh = qh.pop_front();
            t  = qt.pop_front();
            chk(out_valid == v, "R2 valid", int'(out_valid), int'(v));
            if (v) begin
                held_low  = el;
                held_high = eh;
                chk(ah == eh, (t == "R3") ? "R3 high" : {t, " high"}, ah, eh);
                chk(al == el, (t == "R3") ? "R4 low" : {t, " low"}, al, el);
                chk(ah >= -255 && ah <= 255, "R8 high range", ah, 255);
                chk(al >= -128 && al <= 382, "R8 low range", al, 382);
            end else begin
                chk(ah == held_high, "R7 hold high", ah, held_high);
                chk(al == held_low, "R7 hold low", al, held_low);
            end
        end else begin
            chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
            chk(al == 0 && ah == 0, "R1 outputs after reset", al + ah, 0);
        end
    endtask

    task automatic step(bit v, bit s, int e, int o);
        @(negedge clk);
        compare_outputs();
        in_valid = v;
        in_sor   = s;
        in_even  = 8'(e);
        in_odd   = 8'(o);
        if (v) begin
            int el, hl, h, l;
            el = s ? 0 : m_even_prev;
            h  = o - ((e + el) >>> 1);
            hl = s ? 0 : m_high_prev;
            l  = el + ((h + hl) >>> 2);
            m_even_prev = e;
            m_high_prev = h;
            qv.push_back(1'b1);
            ql.push_back(l);
            qh.push_back(h);
            qt.push_back(s ? "R5" : (m_gap ? "R6" : "R3"));
            m_gap = 0;
        end else begin
            m_gap = 1;
            qv.push_back(1'b0);
            ql.push_back(0);
            qh.push_back(0);
            qt.push_back("R2");
        end
    endtask

    initial begin
        // reset phase: outputs must stay cleared (R1)
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0 && out_low == 0 && out_high == 0,
                "R1 during reset", int'(out_valid), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        m_gap = 0;

        // first row after reset without a marker (R5 via reset state)
        for (int k = 0; k < ROW_PAIRS; k++) step(1, 0, 200 - k, 17 * k);

        // saturated row, then empty row, back to back with markers (R5)
        for (int k = 0; k < ROW_PAIRS; k++) step(1, k == 0, 255, 255);
        for (int k = 0; k < ROW_PAIRS; k++) step(1, k == 0, 0, 0);

        // alternating extremes: negative high-pass sums, floor rounding (R4)
        for (int k = 0; k < ROW_PAIRS; k++) step(1, k == 0, (k % 2) ? 255 : 0, (k % 2) ? 0 : 255);
        for (int k = 0; k < ROW_PAIRS; k++) step(1, k == 0, 255, 0);
        for (int k = 0; k < ROW_PAIRS; k++) step(1, k == 0, (k % 3 == 0) ? 1 : 254, (k % 2) ? 3 : 0);

        // marker on an idle cycle must be ignored (R6)
        step(1, 1, 100, 50);
        step(1, 0, 30, 220);
        step(0, 1, 255, 255);
        step(0, 1, 0, 0);
        step(1, 0, 10, 240);
        step(1, 0, 90, 5);

        // random rows with random idle gaps (R3 R4 R5 R6)
        for (int r = 0; r < 60; r++) begin
            for (int k = 0; k < ROW_PAIRS; k++) begin
                while ($urandom_range(3) == 0)
                    step(0, $urandom_range(1), $urandom_range(255), $urandom_range(255));
                step(1, k == 0, $urandom_range(255), $urandom_range(255));
            end
        end

        // continuous random stream with sparse markers
        for (int k = 0; k < 400; k++)
            step(1, $urandom_range(15) == 0, $urandom_range(255), $urandom_range(255));

        // drain the pipeline and check the held values (R7)
        for (int k = 0; k < LAT + 4; k++) step(0, 0, 0, 0);

        finish_run();
    end
endmodule